// File: doc/BRIEF.md
# Program Counter Sequencer with Return Stack

This block holds the instruction fetch address of a small microcontroller core and decides, once per clock, where the next fetch comes from. The instruction decoder drives one-hot style control strobes: advance, conditional skip, low-byte write, jump, call, return and interrupt acknowledge. The block resolves them by a fixed priority and updates an 11-bit counter that spans 2048 program words. Calls and interrupt acknowledges save a return address on a four-entry hardware stack. A return restores the counter from that stack. The stack holds only return addresses and cannot be reached as data.

Control flow runs through a two-state sequencer. In `ST_RUN` the winning command is applied. Any control transfer (jump, call, return, low-byte write, interrupt vector, taken skip) takes transition `T_TRANSFER` into `ST_BUBBLE`. That state asserts `flush` for exactly one cycle so the core can discard the instruction already fetched. In `ST_BUBBLE` every command is ignored and the counter advances by one. Transition `T_RESUME` then returns to `ST_RUN`. A plain advance or an idle cycle takes transition `T_STAY` and remains in `ST_RUN`. The block also forms the table-read address from an 8-bit table pointer. That address either lies in the page of the current counter or in the last page of memory.

Top module: `prog_ctr_stack`

## Requirements
- R1: During and right after reset, `fetch_addr` is 000h, `stk_full` is 0, `flush` is 0 and the state is `ST_RUN`.
- R2: In `ST_RUN`, `adv_en` alone moves `fetch_addr` up by one in the next cycle, and 7FFh wraps to 000h. With no strobe, `fetch_addr` holds its value.
- R3: A taken skip (`skip_en`) adds 2 to `fetch_addr` and asserts `flush` in the next cycle.
- R4: A low-byte write (`pcl_wr`) keeps `fetch_addr` bits 10..8 and replaces bits 7..0 with `pcl_byte`.
- R5: `jump_en` loads `target`. `call_en` loads `target` and pushes `fetch_addr`+1. `ret_en` loads the most recently pushed address and removes it from the stack.
- R6: The stack holds four addresses, and `stk_full` is 1 exactly while four are held. A call made while the stack is full discards the oldest entry, so later returns give back the four most recent addresses.
- R7: A return made with the stack empty loads 000h and leaves the stack empty.
- R8: `irq_ack` loads vector 004h, 008h, 00Ch or 010h for `irq_src` = 0, 1, 2 or 3, and pushes the current `fetch_addr`. While `stk_full` is 1 the acknowledge is ignored, and the next strobe in priority order acts instead.
- R9: When several strobes are high together, the priority is: interrupt acknowledge, return, call, jump, low-byte write, skip, advance.
- R10: After every control transfer, `flush` is 1 for exactly one cycle (`ST_BUBBLE`). During that cycle all strobes are ignored and `fetch_addr` advances by one.
- R11: `tbl_addr` is {`fetch_addr`[10:8], `tbl_ptr`} when `tbl_last` is 0, and {3'b111, `tbl_ptr`} when `tbl_last` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| adv_en | input | 1 | Advance counter by one |
| skip_en | input | 1 | Taken skip, advance by two |
| pcl_wr | input | 1 | Write counter low byte |
| pcl_byte | input | 8 | Low-byte write data |
| jump_en | input | 1 | Jump to `target` |
| call_en | input | 1 | Call `target`, push return address |
| target | input | 11 | Jump or call destination |
| ret_en | input | 1 | Return from stack |
| irq_ack | input | 1 | Interrupt acknowledge request |
| irq_src | input | 2 | Interrupt source selecting the vector |
| tbl_ptr | input | 8 | Table pointer |
| tbl_last | input | 1 | Table read from the last page |
| fetch_addr | output | 11 | Current fetch address |
| tbl_addr | output | 11 | Table-read address |
| stk_full | output | 1 | Stack holds four entries |
| flush | output | 1 | Dummy cycle after a control transfer |

## Verification
The hardest case to reach is the blocked interrupt acknowledge. It needs the stack full, which takes four calls, each followed by its bubble cycle. In that state a fifth call must overwrite the oldest entry without changing the depth. The stimulus nests five calls from distinct addresses, then raises `irq_ack` together with a lower-priority strobe. It then unwinds with six returns, checking that the four newest addresses come back and that the sixth return yields 000h. A bench model of the stack, built as a shifting array, predicts every address.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
    typedef enum logic [2:0] {
        SEL_HOLD,
        SEL_INC,
        SEL_SKIP,
        SEL_PCL,
        SEL_JMP,
        SEL_CALL,
        SEL_RET,
        SEL_IRQ
    } nxt_sel_e;

    typedef enum logic {
        ST_RUN,
        ST_BUBBLE
    } seq_st_e;
endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
    import pcs_pkg::*;
(
    input  logic     in_run,
    input  logic     stk_full,
    input  logic     irq_ack,
    input  logic     ret_en,
    input  logic     call_en,
    input  logic     jump_en,
    input  logic     pcl_wr,
    input  logic     skip_en,
    input  logic     adv_en,
    output nxt_sel_e sel
);
    always_comb begin
        if (!in_run)                   sel = SEL_INC;
        else if (irq_ack && !stk_full) sel = SEL_IRQ;
        else if (ret_en)               sel = SEL_RET;
        else if (call_en)              sel = SEL_CALL;
        else if (jump_en)              sel = SEL_JMP;
        else if (pcl_wr)               sel = SEL_PCL;
        else if (skip_en)              sel = SEL_SKIP;
        else if (adv_en)               sel = SEL_INC;
        else                           sel = SEL_HOLD;
    end
endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
    parameter int AW    = 11,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [AW-1:0] push_val,
    output logic [AW-1:0] top_val,
    output logic          full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [AW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wp;
    logic [PTR_W-1:0] wp_inc;
    logic [PTR_W-1:0] wp_dec;
    logic [CNT_W-1:0] cnt;

    assign wp_inc  = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + PTR_W'(1);
    assign wp_dec  = (wp == '0) ? PTR_W'(DEPTH - 1) : wp - PTR_W'(1);
    assign top_val = (cnt == '0) ? '0 : mem[wp_dec];
    assign full    = (cnt == CNT_W'(DEPTH));

    // Circular buffer: when full, wp points at the oldest entry, so a push
    // overwrites it while the count stays at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[wp] <= push_val;
            wp      <= wp_inc;
            if (!full) cnt <= cnt + CNT_W'(1);
        end else if (pop && cnt != '0) begin
            wp  <= wp_dec;
            cnt <= cnt - CNT_W'(1);
        end
    end

    assert_drop_oldest_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> full);

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt == '0) |=> (cnt == '0 && top_val == '0));

    assert_pop_clears_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && full) |=> !full);
endmodule

// File: rtl/pcs_tbl_addr.sv
module pcs_tbl_addr #(
    parameter int AW     = 11,
    parameter int PAGE_W = 8
) (
    input  logic [AW-1:0]     pc,
    input  logic [PAGE_W-1:0] ptr,
    input  logic              last_page,
    output logic [AW-1:0]     addr
);
    localparam int HI_W = AW - PAGE_W;

    always_comb begin
        if (last_page) addr = {{HI_W{1'b1}}, ptr};
        else           addr = {pc[AW-1:PAGE_W], ptr};
    end
endmodule

// File: rtl/prog_ctr_stack.sv
module prog_ctr_stack
    import pcs_pkg::*;
#(
    parameter int PC_W      = 11,
    parameter int PAGE_W    = 8,
    parameter int STK_DEPTH = 4,
    parameter int SRC_W     = 2,
    parameter int VEC_SHIFT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_en,
    input  logic              skip_en,
    input  logic              pcl_wr,
    input  logic [PAGE_W-1:0] pcl_byte,
    input  logic              jump_en,
    input  logic              call_en,
    input  logic [PC_W-1:0]   target,
    input  logic              ret_en,
    input  logic              irq_ack,
    input  logic [SRC_W-1:0]  irq_src,
    input  logic [PAGE_W-1:0] tbl_ptr,
    input  logic              tbl_last,
    output logic [PC_W-1:0]   fetch_addr,
    output logic [PC_W-1:0]   tbl_addr,
    output logic              stk_full,
    output logic              flush
);
    seq_st_e         state_q;
    seq_st_e         state_d;
    nxt_sel_e        sel;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] pc_plus1;
    logic [PC_W-1:0] vec_addr;
    logic [PC_W-1:0] stk_top;
    logic            transfer;
    logic            push;
    logic            pop;
    logic [PC_W-1:0] push_val;

    pcs_arbiter u_arb (
        .in_run   (state_q == ST_RUN),
        .stk_full (stk_full),
        .irq_ack  (irq_ack),
        .ret_en   (ret_en),
        .call_en  (call_en),
        .jump_en  (jump_en),
        .pcl_wr   (pcl_wr),
        .skip_en  (skip_en),
        .adv_en   (adv_en),
        .sel      (sel)
    );

    assign pc_plus1 = pc_q + PC_W'(1);
    assign vec_addr = (PC_W'(irq_src) + PC_W'(1)) << VEC_SHIFT;
    assign push     = (sel == SEL_CALL) || (sel == SEL_IRQ);
    assign pop      = (sel == SEL_RET);
    assign push_val = (sel == SEL_CALL) ? pc_plus1 : pc_q;

    pcs_ret_stack #(.AW(PC_W), .DEPTH(STK_DEPTH)) u_stk (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .push_val (push_val),
        .top_val  (stk_top),
        .full     (stk_full)
    );

    pcs_tbl_addr #(.AW(PC_W), .PAGE_W(PAGE_W)) u_tbl (
        .pc        (pc_q),
        .ptr       (tbl_ptr),
        .last_page (tbl_last),
        .addr      (tbl_addr)
    );

    always_comb begin
        unique case (sel)
            SEL_HOLD: pc_d = pc_q;
            SEL_INC:  pc_d = pc_plus1;
            SEL_SKIP: pc_d = pc_q + PC_W'(2);
            SEL_PCL:  pc_d = {pc_q[PC_W-1:PAGE_W], pcl_byte};
            SEL_JMP:  pc_d = target;
            SEL_CALL: pc_d = target;
            SEL_RET:  pc_d = stk_top;
            SEL_IRQ:  pc_d = vec_addr;
            default:  pc_d = pc_q;
        endcase
    end

    assign transfer = (sel != SEL_HOLD) && (sel != SEL_INC);

    // Next-state logic: T_TRANSFER, T_RESUME, T_STAY
    always_comb begin
        unique case (state_q)
            ST_RUN:    state_d = transfer ? ST_BUBBLE : ST_RUN;
            ST_BUBBLE: state_d = ST_RUN;
            default:   state_d = ST_RUN;
        endcase
    end

    // State and counter register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
        end
    end

    // Outputs
    always_comb begin
        fetch_addr = pc_q;
        flush      = (state_q == ST_BUBBLE);
    end

    assert_bubble_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BUBBLE) |=> (state_q == ST_RUN && pc_q == $past(pc_q) + PC_W'(1)));

    assert_page_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_PCL) |=> (pc_q[PC_W-1:PAGE_W] == $past(pc_q[PC_W-1:PAGE_W])
                              && pc_q[PAGE_W-1:0] == $past(pcl_byte)));

    assert_skip_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_SKIP) |=> (pc_q == $past(pc_q) + PC_W'(2) && flush));

    assert_irq_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && stk_full) |-> (sel != SEL_IRQ));
endmodule

// File: tb/test_prog_ctr_stack.sv
module test_prog_ctr_stack;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        adv_en = 0, skip_en = 0, pcl_wr = 0, jump_en = 0, call_en = 0;
    logic        ret_en = 0, irq_ack = 0, tbl_last = 0;
    logic [7:0]  pcl_byte = 0, tbl_ptr = 0;
    logic [10:0] target = 0;
    logic [1:0]  irq_src = 0;
    logic [10:0] fetch_addr, tbl_addr;
    logic        stk_full, flush;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int m_pc = 0;
    int m_stk[4];
    int m_cnt = 0;
    bit m_bub = 0;

    always #4 clk = ~clk;

    prog_ctr_stack i_prog_ctr_stack (
        .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .skip_en(skip_en),
        .pcl_wr(pcl_wr), .pcl_byte(pcl_byte), .jump_en(jump_en),
        .call_en(call_en), .target(target), .ret_en(ret_en),
        .irq_ack(irq_ack), .irq_src(irq_src), .tbl_ptr(tbl_ptr),
        .tbl_last(tbl_last), .fetch_addr(fetch_addr), .tbl_addr(tbl_addr),
        .stk_full(stk_full), .flush(flush)
    );

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic m_push(input int v);
        if (m_cnt == 4) begin
            for (int i = 0; i < 3; i++) m_stk[i] = m_stk[i+1];
            m_stk[3] = v;
        end else begin
            m_stk[m_cnt] = v;
            m_cnt++;
        end
    endtask

    function automatic int m_pop();
        if (m_cnt == 0) return 0;
        m_cnt--;
        return m_stk[m_cnt];
    endfunction

    task automatic clear_in();
        adv_en = 0; skip_en = 0; pcl_wr = 0; jump_en = 0;
        call_en = 0; ret_en = 0; irq_ack = 0;
    endtask

    // Inputs are set before calling; the model applies the requirements.
    task automatic tick(input string tag);
        if (m_bub) begin
            m_pc = (m_pc + 1) % 2048; m_bub = 0;
        end else if (irq_ack && m_cnt < 4) begin
            m_push(m_pc); m_pc = (int'(irq_src) + 1) * 4; m_bub = 1;
        end else if (ret_en) begin
            m_pc = m_pop(); m_bub = 1;
        end else if (call_en) begin
            m_push((m_pc + 1) % 2048); m_pc = int'(target); m_bub = 1;
        end else if (jump_en) begin
            m_pc = int'(target); m_bub = 1;
        end else if (pcl_wr) begin
            m_pc = (m_pc & 32'h700) | int'(pcl_byte); m_bub = 1;
        end else if (skip_en) begin
            m_pc = (m_pc + 2) % 2048; m_bub = 1;
        end else if (adv_en) begin
            m_pc = (m_pc + 1) % 2048;
        end
        @(posedge clk);
        @(negedge clk);
        clear_in();
        chk(int'(fetch_addr), m_pc, {tag, " addr"});
        chk(int'(flush), int'(m_bub), {tag, " flush"});
        chk(int'(stk_full), int'(m_cnt == 4), {tag, " full"});
    endtask

    task automatic go_to(input int a);
        jump_en = 1; target = 11'(a); tick("R5 jump");
        tick("R10 bubble");
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        tbl_ptr = 8'hAB;
        chk(int'(fetch_addr), 0, "R1 reset addr");
        chk(int'(stk_full), 0, "R1 reset full");
        chk(int'(flush), 0, "R1 reset flush");
        rst_n = 1;
        tick("R1 idle after reset");

        // R2: advance sweep, hold, wrap
        for (int i = 0; i < 20; i++) begin adv_en = 1; tick("R2 advance"); end
        tick("R2 hold");
        go_to(11'h7FD);
        adv_en = 1; tick("R2 to 7FF");
        adv_en = 1; tick("R2 wrap");

        // R3: skips across pages, including wrap
        for (int p = 0; p < 8; p++) begin
            go_to(p * 256 + 253);
            skip_en = 1; tick("R3 skip");
            tick("R10 bubble after skip");
        end

        // R4: low-byte writes in every page
        for (int p = 0; p < 8; p++) begin
            go_to(p * 256 + 7);
            for (int b = 0; b < 256; b += 37) begin
                pcl_wr = 1; pcl_byte = 8'(b); tick("R4 pcl write");
                tick("R10 bubble after pcl");
            end
        end

        // R11: table address sweep in two pages
        for (int p = 2; p < 8; p += 5) begin
            go_to(p * 256 + 1);
            for (int t = 0; t < 256; t++) begin
                tbl_ptr = 8'(t);
                tbl_last = 0; #1;
                chk(int'(tbl_addr), p * 256 + t, "R11 current page");
                tbl_last = 1; #1;
                chk(int'(tbl_addr), 32'h700 + t, "R11 last page");
            end
        end

        // R6: five nested calls, then R8 blocked irq, then six returns
        go_to(11'h100);
        for (int k = 0; k < 5; k++) begin
            call_en = 1; target = 11'(11'h200 + k * 11'h40); tick("R6 call");
            adv_en = 1; tick("R10 bubble ignores adv");
            adv_en = 1; tick("R2 advance in callee");
        end
        irq_ack = 1; irq_src = 2; jump_en = 1; target = 11'h333;
        tick("R8 blocked irq lets jump act");
        tick("R10 bubble");
        for (int k = 0; k < 6; k++) begin
            ret_en = 1; tick("R6 R7 return");
            tick("R10 bubble after ret");
        end
        ret_en = 1; tick("R7 empty return");
        tick("R10 bubble");

        // R8: each vector
        for (int s = 0; s < 4; s++) begin
            go_to(11'h0A0 + s);
            irq_ack = 1; irq_src = 2'(s); tick("R8 vector");
            tick("R10 bubble after irq");
            ret_en = 1; tick("R8 return to interrupted addr");
            tick("R10 bubble");
        end

        // R9: priority, removing the winner one by one
        for (int lvl = 0; lvl < 7; lvl++) begin
            go_to(11'h480);
            irq_ack = (lvl <= 0); irq_src = 1;
            ret_en  = (lvl <= 1);
            call_en = (lvl <= 2); target = 11'h5C3;
            jump_en = (lvl <= 3);
            pcl_wr  = (lvl <= 4); pcl_byte = 8'h2E;
            skip_en = (lvl <= 5);
            adv_en  = 1;
            tick("R9 priority");
            if (m_bub) tick("R10 bubble");
            while (m_cnt > 0) begin
                ret_en = 1; tick("R9 unwind"); tick("R10 bubble");
            end
        end

        // R10: a jump in the bubble is ignored
        go_to(11'h010);
        jump_en = 1; target = 11'h654; tick("R5 jump");
        jump_en = 1; target = 11'h111; tick("R10 jump in bubble ignored");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule